// File: doc/BRIEF.md
# Save-RAM Image Transfer Controller

This block copies the battery-backed save memory of an emulated console to and from a raw image file held by a host processor. The image has no filesystem structure: byte `k` of the file is byte `k` of save RAM. The image is 8 KiB or 32 KiB long, so a transfer covers 16 or 64 sectors of 512 bytes. The host moves one sector at a time through a sector buffer inside the block. The block asks for a sector by placing its index on an LBA output and raising a read or a write request. The host answers with an acknowledge and moves the bytes through its own buffer port while the acknowledge is high.

A mount event loads the whole image into save RAM. A save command writes all of save RAM back to the image. For a load, each sector is fetched from the host and then copied from the buffer into save RAM. For a save, each sector is first copied from save RAM into the buffer and then handed to the host. The console is frozen for the whole transfer. It receives a fixed-length reset pulse at the end of the transfer, and the controller then returns to idle. An event that arrives while a transfer is running has no effect.

Top module: `save_image_xfer`

## Requirements
- R1: After reset, `busy`, `console_hold`, `console_rst`, `sec_rd_req`, `sec_wr_req` and `sram_we` are all low.
- R2: A transfer requests sectors with LBA 0, 1, 2, … in order. The count is 16 when `size_big` is 0 (8 KiB image) and 64 when `size_big` is 1 (32 KiB image).
- R3: A request stays high, with a stable LBA, until the acknowledge is seen. It is low on the cycle after the acknowledge is first seen, and the next request comes only after the acknowledge has fallen.
- R4: During a load, the byte that the host writes at buffer index `i` while sector `s` is acknowledged is written to save RAM address `s*512+i`. Every address of the image is written exactly once, in increasing address order.
- R5: During a save, a host read of buffer index `i` while sector `s` is acknowledged returns save RAM byte `s*512+i`. The read data appears one clock after the address.
- R6: A load raises only read requests. A save raises only write requests and never asserts `sram_we`.
- R7: `busy` and `console_hold` go high on the clock after the accepted event. They stay high whenever a request, an acknowledge, a save RAM write or the console reset is active.
- R8: Each transfer ends with `console_rst` high for exactly 16 consecutive cycles, after which `busy` and `console_hold` fall together.
- R9: A save command that arrives during a load has no effect: no write request follows, and the controller stays idle after the load completes.
- R10: When a mount event and a save command arrive in the same idle cycle, the load is carried out and the save is dropped.
- R11: The image size is captured when a transfer starts. A change of `size_big` during the transfer does not change its sector count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the host interface and save RAM |
| rst | input | 1 | Synchronous active-high reset |
| mount_evt | input | 1 | One-cycle pulse: image mounted, load it into save RAM |
| save_evt | input | 1 | One-cycle pulse: user asked to write save RAM to the image |
| size_big | input | 1 | Image size: 0 = 8 KiB, 1 = 32 KiB |
| sec_lba | output | 16 | Sector index of the current request, in 512-byte units |
| sec_rd_req | output | 1 | Request a sector from the host (load) |
| sec_wr_req | output | 1 | Offer a sector to the host (save) |
| sec_ack | input | 1 | Host acknowledge; high while the sector moves |
| hbuf_addr | input | 9 | Host byte index into the sector buffer |
| hbuf_wdata | input | 8 | Host write data to the sector buffer |
| hbuf_we | input | 1 | Host write strobe, one byte per pulse |
| hbuf_rdata | output | 8 | Sector buffer data for the host, one cycle after the address |
| sram_addr | output | 15 | Save RAM byte address |
| sram_wdata | output | 8 | Save RAM write data |
| sram_we | output | 1 | Save RAM write enable |
| sram_rdata | input | 8 | Save RAM read data, one cycle after the address |
| console_hold | output | 1 | Freezes the console clock while high |
| console_rst | output | 1 | Console reset pulse at the end of a transfer |
| busy | output | 1 | A transfer or its closing reset is in progress |

## Verification
The assertions assume a well-behaved host. It raises the acknowledge only in answer to a pending request, holds it high while it moves bytes, and moves bytes only while it is high. They also assume save RAM returns data exactly one clock after the address. The bench host model waits a random 0 to 3 cycles before it acknowledges and inserts random idle cycles between byte strobes. It always finishes a full sector before it lowers the acknowledge, and its save RAM model is a one-cycle registered pattern generator. Events are single-cycle pulses driven between clock edges. The bench deliberately injects conflicting events and mid-transfer size changes, and these fall within the assumed host behaviour.

// File: rtl/sxfer_pkg.sv
package sxfer_pkg;

    localparam int SECTOR_BYTES = 512;
    localparam int SECT_IDX_W   = $clog2(SECTOR_BYTES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ACKED,
        ST_COPY,
        ST_RST
    } seq_state_t;

    typedef enum logic {
        DIR_LOAD,
        DIR_STORE
    } xfer_dir_t;

    typedef struct packed {
        logic                  valid;
        logic [SECT_IDX_W-1:0] idx;
    } copy_beat_t;

    function automatic int sectors_for(input int bytes);
        return bytes / SECTOR_BYTES;
    endfunction

endpackage

// File: rtl/sect_buf.sv
module sect_buf #(
    parameter int DEPTH = 512,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    input  logic          a_we,
    output logic [DW-1:0] a_rdata,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    input  logic          b_we,
    output logic [DW-1:0] b_rdata
);

    logic [DW-1:0] mem [DEPTH];

    // The two ports never write in the same phase: the host writes while
    // the sector is acknowledged, the copier while the controller copies.
    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wdata;
        if (b_we) mem[b_addr] <= b_wdata;
        a_rdata <= mem[a_addr];
        b_rdata <= mem[b_addr];
    end

endmodule

// File: rtl/sector_copier.sv
module sector_copier
    import sxfer_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    output logic [SECT_IDX_W-1:0] rd_idx,
    output logic                  wr_valid,
    output logic [SECT_IDX_W-1:0] wr_idx,
    output logic                  done
);

    logic [SECT_IDX_W:0] cnt;
    copy_beat_t          beat;

    // Read side issues index cnt; both sources answer one clock later,
    // so the write side replays the index from the previous cycle.
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            beat <= '0;
        end else if (!cnt[SECT_IDX_W]) begin
            cnt        <= cnt + 1'b1;
            beat.valid <= 1'b1;
            beat.idx   <= cnt[SECT_IDX_W-1:0];
        end else begin
            beat.valid <= 1'b0;
        end
    end

    assign rd_idx   = cnt[SECT_IDX_W-1:0];
    assign wr_valid = beat.valid;
    assign wr_idx   = beat.idx;
    assign done     = en && cnt[SECT_IDX_W] && !beat.valid;

endmodule

// File: rtl/xfer_sequencer.sv
module xfer_sequencer
    import sxfer_pkg::*;
#(
    parameter int SECT_W      = 6,
    parameter int SMALL_SECTS = 16,
    parameter int LARGE_SECTS = 64,
    parameter int RST_CYC     = 16,
    localparam int RC_W       = $clog2(RST_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mount_evt,
    input  logic              save_evt,
    input  logic              size_big,
    input  logic              ack,
    input  logic              copy_done,
    output seq_state_t        state,
    output xfer_dir_t         dir,
    output logic [SECT_W-1:0] sector,
    output logic              rd_req,
    output logic              wr_req,
    output logic              busy,
    output logic              console_rst
);

    logic [SECT_W-1:0] last_sect;
    logic [RC_W-1:0]   rcnt;
    logic              at_last;

    assign at_last = (sector == last_sect);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            dir       <= DIR_LOAD;
            sector    <= '0;
            last_sect <= '0;
            rcnt      <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    sector    <= '0;
                    rcnt      <= '0;
                    last_sect <= size_big ? SECT_W'(LARGE_SECTS - 1)
                                          : SECT_W'(SMALL_SECTS - 1);
                    if (mount_evt) begin
                        dir   <= DIR_LOAD;
                        state <= ST_REQ;
                    end else if (save_evt) begin
                        dir   <= DIR_STORE;
                        state <= ST_COPY;
                    end
                end
                ST_REQ: begin
                    if (ack) state <= ST_ACKED;
                end
                ST_ACKED: begin
                    if (!ack) begin
                        if (dir == DIR_LOAD) begin
                            state <= ST_COPY;
                        end else if (at_last) begin
                            state <= ST_RST;
                        end else begin
                            sector <= sector + 1'b1;
                            state  <= ST_COPY;
                        end
                    end
                end
                ST_COPY: begin
                    if (copy_done) begin
                        if (dir == DIR_STORE) begin
                            state <= ST_REQ;
                        end else if (at_last) begin
                            state <= ST_RST;
                        end else begin
                            sector <= sector + 1'b1;
                            state  <= ST_REQ;
                        end
                    end
                end
                ST_RST: begin
                    rcnt <= rcnt + 1'b1;
                    if (rcnt == RC_W'(RST_CYC - 1)) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rd_req      = (state == ST_REQ) && (dir == DIR_LOAD);
    assign wr_req      = (state == ST_REQ) && (dir == DIR_STORE);
    assign busy        = (state != ST_IDLE);
    assign console_rst = (state == ST_RST);

endmodule

// File: rtl/save_image_xfer.sv
module save_image_xfer
    import sxfer_pkg::*;
#(
    parameter int SRAM_AW     = 15,
    parameter int LBA_W       = 16,
    parameter int SMALL_BYTES = 8192,
    parameter int LARGE_BYTES = 32768,
    parameter int RST_CYC     = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mount_evt,
    input  logic               save_evt,
    input  logic               size_big,
    output logic [LBA_W-1:0]   sec_lba,
    output logic               sec_rd_req,
    output logic               sec_wr_req,
    input  logic               sec_ack,
    input  logic [8:0]         hbuf_addr,
    input  logic [7:0]         hbuf_wdata,
    input  logic               hbuf_we,
    output logic [7:0]         hbuf_rdata,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic [7:0]         sram_wdata,
    output logic               sram_we,
    input  logic [7:0]         sram_rdata,
    output logic               console_hold,
    output logic               console_rst,
    output logic               busy
);

    localparam int SECT_W      = SRAM_AW - SECT_IDX_W;
    localparam int SMALL_SECTS = sectors_for(SMALL_BYTES);
    localparam int LARGE_SECTS = sectors_for(LARGE_BYTES);

    seq_state_t            state;
    xfer_dir_t             dir;
    logic [SECT_W-1:0]     sector;
    logic                  copy_done;
    logic [SECT_IDX_W-1:0] rd_idx;
    logic [SECT_IDX_W-1:0] wr_idx;
    logic                  wr_valid;
    logic [SECT_IDX_W-1:0] b_addr;
    logic [7:0]            b_wdata;
    logic                  b_we;
    logic [7:0]            b_rdata;

    xfer_sequencer #(
        .SECT_W     (SECT_W),
        .SMALL_SECTS(SMALL_SECTS),
        .LARGE_SECTS(LARGE_SECTS),
        .RST_CYC    (RST_CYC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .mount_evt  (mount_evt),
        .save_evt   (save_evt),
        .size_big   (size_big),
        .ack        (sec_ack),
        .copy_done  (copy_done),
        .state      (state),
        .dir        (dir),
        .sector     (sector),
        .rd_req     (sec_rd_req),
        .wr_req     (sec_wr_req),
        .busy       (busy),
        .console_rst(console_rst)
    );

    sector_copier u_copy (
        .clk     (clk),
        .rst     (rst),
        .en      (state == ST_COPY),
        .rd_idx  (rd_idx),
        .wr_valid(wr_valid),
        .wr_idx  (wr_idx),
        .done    (copy_done)
    );

    sect_buf #(
        .DEPTH(SECTOR_BYTES),
        .DW   (8)
    ) u_buf (
        .clk    (clk),
        .a_addr (hbuf_addr),
        .a_wdata(hbuf_wdata),
        .a_we   (hbuf_we),
        .a_rdata(hbuf_rdata),
        .b_addr (b_addr),
        .b_wdata(b_wdata),
        .b_we   (b_we),
        .b_rdata(b_rdata)
    );

    // Load: buffer -> save RAM. Store: save RAM -> buffer.
    always_comb begin
        if (dir == DIR_LOAD) begin
            b_addr     = rd_idx;
            b_we       = 1'b0;
            b_wdata    = '0;
            sram_addr  = {sector, wr_idx};
            sram_we    = wr_valid;
            sram_wdata = b_rdata;
        end else begin
            b_addr     = wr_idx;
            b_we       = wr_valid;
            b_wdata    = sram_rdata;
            sram_addr  = {sector, rd_idx};
            sram_we    = 1'b0;
            sram_wdata = '0;
        end
    end

    assign sec_lba      = {{(LBA_W - SECT_W){1'b0}}, sector};
    assign console_hold = busy;

endmodule

// File: rtl/sxfer_checks.sv
module sxfer_checks #(
    parameter int LBA_W   = 16,
    parameter int RST_CYC = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             sec_rd_req,
    input logic             sec_wr_req,
    input logic             sec_ack,
    input logic [LBA_W-1:0] sec_lba,
    input logic             sram_we,
    input logic             busy,
    input logic             console_hold,
    input logic             console_rst
);

    logic any_req;
    int   rst_run;

    assign any_req = sec_rd_req || sec_wr_req;

    always_ff @(posedge clk) begin
        if (rst || !console_rst) rst_run <= 0;
        else                     rst_run <= rst_run + 1;
    end

    // R3
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (any_req && sec_ack) |=> !any_req);

    // R3
    lba_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (any_req && $past(any_req)) |-> $stable(sec_lba));

    // R7
    hold_cover_chk: assert property (@(posedge clk) disable iff (rst)
        (any_req || sec_ack || sram_we || console_rst) |-> (busy && console_hold));

    // R6
    one_dir_chk: assert property (@(posedge clk) disable iff (rst)
        !(sec_wr_req && sram_we));

    // R8
    rst_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(console_rst) |-> (rst_run == RST_CYC));

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(console_rst));

endmodule

bind save_image_xfer sxfer_checks #(
    .LBA_W  (LBA_W),
    .RST_CYC(RST_CYC)
) u_checks (
    .clk         (clk),
    .rst         (rst),
    .sec_rd_req  (sec_rd_req),
    .sec_wr_req  (sec_wr_req),
    .sec_ack     (sec_ack),
    .sec_lba     (sec_lba),
    .sram_we     (sram_we),
    .busy        (busy),
    .console_hold(console_hold),
    .console_rst (console_rst)
);

// File: tb/save_image_xfer_test.sv
module save_image_xfer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mount_evt = 1'b0;
    logic        save_evt = 1'b0;
    logic        size_big = 1'b0;
    logic [15:0] sec_lba;
    logic        sec_rd_req, sec_wr_req;
    logic        sec_ack = 1'b0;
    logic [8:0]  hbuf_addr = '0;
    logic [7:0]  hbuf_wdata = '0;
    logic        hbuf_we = 1'b0;
    logic [7:0]  hbuf_rdata;
    logic [14:0] sram_addr;
    logic [7:0]  sram_wdata;
    logic        sram_we;
    logic [7:0]  sram_rdata = '0;
    logic        console_hold, console_rst, busy;

    always #5 clk = ~clk;

    save_image_xfer uut (.*);

    int n_checks = 0, n_fails = 0;
    int n_sect, n_wr, n_rd, exp_waddr;
    int bad_lba, bad_req, bad_data, bad_rd, bad_hold, bad_end;
    int rst_cycles, rd_seen, wr_seen;
    bit gaps = 1'b0;
    bit prev_rst = 1'b0;
    logic [7:0] seed_ld = 8'h00, seed_sv = 8'h00;

    function automatic logic [7:0] img_byte(input int a);
        return 8'((a * 13) ^ (a >> 7)) ^ seed_ld;
    endfunction

    function automatic logic [7:0] ram_byte(input int a);
        return 8'((a * 29) + (a >> 5)) ^ seed_sv;
    endfunction

    // save RAM model: registered read, one cycle of latency
    always @(posedge clk) sram_rdata <= ram_byte(int'(sram_addr));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    task automatic clear_counts();
        n_sect = 0; n_wr = 0; n_rd = 0; exp_waddr = 0;
        bad_lba = 0; bad_req = 0; bad_data = 0; bad_rd = 0;
        bad_hold = 0; bad_end = 0; rst_cycles = 0; rd_seen = 0; wr_seen = 0;
    endtask

    // port monitors, sampled between edges
    always @(negedge clk) begin
        if (!rst) begin
            if (sram_we) begin
                if (int'(sram_addr) != exp_waddr || sram_wdata != img_byte(int'(sram_addr)))
                    bad_data++;
                exp_waddr++;
                n_wr++;
            end
            if (sec_rd_req) rd_seen++;
            if (sec_wr_req) wr_seen++;
            if (console_rst) rst_cycles++;
            if ((sec_rd_req || sec_wr_req || sec_ack || sram_we || console_rst)
                && !(busy && console_hold)) bad_hold++;
            if (prev_rst && !console_rst && (busy || console_hold)) bad_end++;
            prev_rst = console_rst;
        end
    end

    // host model
    task automatic serve();
        bit rd = sec_rd_req;
        int lba = int'(sec_lba);
        int dly = gaps ? int'($urandom_range(0, 3)) : 0;
        if (lba != n_sect) bad_lba++;
        n_sect++;
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            if (!(rd ? sec_rd_req : sec_wr_req) || int'(sec_lba) != lba) bad_req++;
        end
        sec_ack = 1'b1;
        @(negedge clk);
        if (sec_rd_req || sec_wr_req) bad_req++;
        if (rd) begin
            for (int i = 0; i < 512; i++) begin
                hbuf_addr  = 9'(i);
                hbuf_wdata = img_byte(lba * 512 + i);
                hbuf_we    = 1'b1;
                @(negedge clk);
                hbuf_we = 1'b0;
                if (gaps && $urandom_range(0, 3) == 0) @(negedge clk);
            end
        end else begin
            for (int i = 0; i < 512; i++) begin
                hbuf_addr = 9'(i);
                @(negedge clk);
                if (hbuf_rdata != ram_byte(lba * 512 + i)) bad_rd++;
                n_rd++;
            end
        end
        sec_ack = 1'b0;
        @(negedge clk);
        if (sec_rd_req || sec_wr_req) bad_req++;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (!rst && (sec_rd_req || sec_wr_req)) serve();
        end
    end

    // mode: 0 load, 1 save; extra: 1 = other event same cycle,
    // 2 = save command mid-load, 3 = size flip mid-transfer
    task automatic run(input bit save, input bit big, input int extra);
        int exp_s = big ? 64 : 16;
        string tag = save ? "save" : "load";
        clear_counts();
        seed_ld = 8'($urandom);
        seed_sv = 8'($urandom);
        size_big = big;
        @(negedge clk);
        if (save) save_evt = 1'b1; else mount_evt = 1'b1;
        if (extra == 1) save_evt = 1'b1;
        @(negedge clk);
        mount_evt = 1'b0;
        save_evt  = 1'b0;
        // R7: busy and hold rise on the clock after the event
        check(busy && console_hold, {"R7 busy rise ", tag}, int'(busy), 1);
        while (busy) begin
            @(negedge clk);
            if (extra == 2 && n_sect == 3 && !sec_ack) save_evt = 1'b1;
            else save_evt = 1'b0;
            if (extra == 3 && n_sect == 2) size_big = ~big;
        end
        save_evt = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (busy) bad_end++;
        end
        // R2: sector count, R11 when size flipped mid-run
        check(n_sect == exp_s, extra == 3 ? "R11 size latched" : {"R2 sector count ", tag},
              n_sect, exp_s);
        check(bad_lba == 0, {"R2 lba order ", tag}, bad_lba, 0);
        check(bad_req == 0, {"R3 request handshake ", tag}, bad_req, 0);
        if (!save) begin
            check(n_wr == exp_s * 512, "R4 write count", n_wr, exp_s * 512);
            check(bad_data == 0, "R4 write data/address", bad_data, 0);
            check(wr_seen == 0, extra == 2 ? "R9 save during load" :
                  (extra == 1 ? "R10 load wins" : "R6 load direction"), wr_seen, 0);
        end else begin
            check(n_rd == exp_s * 512, "R5 read count", n_rd, exp_s * 512);
            check(bad_rd == 0, "R5 read data", bad_rd, 0);
            check(n_wr == 0 && rd_seen == 0, "R6 save direction", n_wr + rd_seen, 0);
        end
        check(bad_hold == 0, {"R7 hold coverage ", tag}, bad_hold, 0);
        check(rst_cycles == 16, {"R8 reset length ", tag}, rst_cycles, 16);
        check(bad_end == 0, {"R8/R9 idle after ", tag}, bad_end, 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(!busy && !console_hold && !console_rst && !sec_rd_req && !sec_wr_req && !sram_we,
              "R1 reset state",
              {26'd0, busy, console_hold, console_rst, sec_rd_req, sec_wr_req, sram_we}, 0);
        gaps = 1'b1;
        run(1'b0, 1'b0, 3);   // small load, size flips mid-run (R11)
        run(1'b0, 1'b0, 2);   // small load, save command mid-run (R9)
        gaps = 1'b0;
        run(1'b0, 1'b1, 1);   // large load, mount and save together (R10)
        run(1'b1, 1'b1, 0);   // large save
        summary();
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual %0d expected %0d", 195000, 0);
        summary();
    end

endmodule